// File: doc/BRIEF.md
# I/O Wait-State Generator

This block drives the CPU READY line during bus cycles on a small processor board. A bus cycle begins when the I/O read, I/O write or memory read strobe is low at a rising clock edge. At that edge READY falls. It rises again once a down-counter has expired and the synchronized channel-ready line is high. The counter is loaded from a 3-bit wait count for I/O cycles and with zero for memory cycles. A register elsewhere in the chip holds the wait count. The clock comes from an external generator.

Expansion cards take part in two ways. A slow card holds channel-ready low to stretch the cycle. This input is asynchronous and passes through a two-flop synchronizer. A fast card pulls the active-low zero-wait-state request to end the cycle at once. A second READY output for the DMA controller comes from the same decision logic and always carries the same value.

All pins are plain level control signals. There is no data stream, so no valid/ready handshake and no back-pressure. All inputs except channel-ready are sampled synchronously to the CPU clock.

Top module: `io_wait_gen`

## Requirements
- R1: While `rst_n` is low, and afterwards until a strobe is sampled low, `cpu_ready` and `dma_ready` are 1.
- R2: For an I/O cycle (`io_rd_n` or `io_wr_n` low) with `io_waits` = N in 0..4 and `chan_rdy` high, `cpu_ready` falls at the first rising edge that samples the strobe low. It stays 0 for exactly N+1 clock periods.
- R3: Wait count values 5, 6 and 7 act as 4, giving 5 low clock periods on an I/O cycle.
- R4: A memory read cycle (`mem_rd_n` low, both I/O strobes high) ignores `io_waits` and keeps `cpu_ready` low for exactly 1 clock period.
- R5: `chan_rdy` is synchronized through two flip-flops. Let edge 0 be the edge where the cycle starts, and let `chan_rdy` be low and then raised just before edge k (k ≥ 1). `cpu_ready` then rises at edge max(N+1, k+2), where N is the effective wait count (0 for memory cycles).
- R6: If `zws_n` is low at the starting edge, `cpu_ready` never falls. If it is low at a later edge while waiting, `cpu_ready` is 1 from that edge.
- R7: Once `cpu_ready` has risen it stays 1 while the strobe stays low. A new cycle needs all strobes high for at least one edge.
- R8: If all strobes go high while waiting, `cpu_ready` returns to 1 at the next edge.
- R9: `dma_ready` equals `cpu_ready` at all times.
- R10: Outside a bus cycle, `chan_rdy` low and `zws_n` low have no effect; `cpu_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| chan_rdy | input | 1 | Channel ready from expansion cards, asynchronous, low = stretch |
| zws_n | input | 1 | Zero-wait-state request, active low |
| io_waits | input | 3 | Programmed I/O wait count (5..7 act as 4) |
| cpu_ready | output | 1 | READY to the CPU |
| dma_ready | output | 1 | READY to the DMA controller |

## Verification
I/O read, I/O write and memory read cycles are run with every wait count from 0 to 7. This separates the programmed delay from the clamp and from the memory path, which must not see the count. Channel-ready is dropped and raised at chosen edges, both before and after the counter expires. The measured low time then shows whether the two-flop latency adds to the programmed delay or overlaps it. Zero-wait requests are placed at the starting edge, in mid-wait and after the natural release; these separate a cycle that never drops from early termination and from a request that has no effect. Strobe removal during a wait and idle-time toggling of channel-ready and the zero-wait request check the abort and ignore paths. Random cycles mix all of these.

// File: rtl/io_wait_pkg.sv
package io_wait_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_WAIT = 2'd1,
    WS_HOLD = 2'd2
  } ws_state_t;

  // Limit a requested count to the supported maximum
  function automatic int unsigned ws_clamp(input int unsigned req, input int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction

endpackage

// File: rtl/io_wait_sync.sv
module io_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/io_wait_decode.sv
module io_wait_decode #(
  parameter int CNT_W    = 3,
  parameter int MAX_WAIT = 4,
  localparam int LOAD_W  = $clog2(MAX_WAIT + 1)
) (
  input  logic             io_rd_n,
  input  logic             io_wr_n,
  input  logic             mem_rd_n,
  input  logic [CNT_W-1:0] io_waits,
  output logic             any_act,
  output logic [LOAD_W-1:0] load_val
);
  import io_wait_pkg::*;

  logic io_act;
  int unsigned clamped;

  always_comb begin
    io_act   = !io_rd_n || !io_wr_n;
    any_act  = io_act || !mem_rd_n;
    clamped  = ws_clamp(int'(io_waits), MAX_WAIT);
    load_val = io_act ? LOAD_W'(clamped) : '0;
  end
endmodule

// File: rtl/io_wait_ctrl.sv
module io_wait_ctrl #(
  parameter int LOAD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_act,
  input  logic [LOAD_W-1:0] load_val,
  input  logic              cr_ok,
  input  logic              zws_req,
  output logic              rdy_cpu,
  output logic              rdy_dma
);
  import io_wait_pkg::*;

  ws_state_t         st, st_nx;
  logic [LOAD_W-1:0] cnt, cnt_nx;
  logic              rdy_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    rdy_nx = rdy_cpu;
    unique case (st)
      WS_IDLE: begin
        rdy_nx = 1'b1;
        if (any_act) begin
          if (zws_req) begin
            st_nx = WS_HOLD;
          end else begin
            st_nx  = WS_WAIT;
            rdy_nx = 1'b0;
            cnt_nx = load_val;
          end
        end
      end
      WS_WAIT: begin
        if (!any_act) begin
          st_nx  = WS_IDLE;
          rdy_nx = 1'b1;
        end else if (zws_req) begin
          st_nx  = WS_HOLD;
          rdy_nx = 1'b1;
        end else if (cnt != '0) begin
          cnt_nx = cnt - 1'b1;
        end else if (cr_ok) begin
          st_nx  = WS_HOLD;
          rdy_nx = 1'b1;
        end
      end
      WS_HOLD: begin
        rdy_nx = 1'b1;
        if (!any_act) st_nx = WS_IDLE;
      end
      default: begin
        st_nx  = WS_IDLE;
        rdy_nx = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= WS_IDLE;
      cnt     <= '0;
      rdy_cpu <= 1'b1;
      rdy_dma <= 1'b1;
    end else begin
      st      <= st_nx;
      cnt     <= cnt_nx;
      rdy_cpu <= rdy_nx;
      rdy_dma <= rdy_nx;
    end
  end
endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen #(
  parameter int CNT_W       = 3,
  parameter int MAX_WAIT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_rd_n,
  input  logic             io_wr_n,
  input  logic             mem_rd_n,
  input  logic             chan_rdy,
  input  logic             zws_n,
  input  logic [CNT_W-1:0] io_waits,
  output logic             cpu_ready,
  output logic             dma_ready
);
  localparam int LOAD_W = $clog2(MAX_WAIT + 1);

  logic              any_act;
  logic [LOAD_W-1:0] load_val;
  logic              cr_sync;

  io_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(chan_rdy), .sync_out(cr_sync)
  );

  io_wait_decode #(.CNT_W(CNT_W), .MAX_WAIT(MAX_WAIT)) u_dec (
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .mem_rd_n(mem_rd_n),
    .io_waits(io_waits), .any_act(any_act), .load_val(load_val)
  );

  io_wait_ctrl #(.LOAD_W(LOAD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .any_act(any_act), .load_val(load_val),
    .cr_ok(cr_sync), .zws_req(!zws_n),
    .rdy_cpu(cpu_ready), .rdy_dma(dma_ready)
  );
endmodule

// File: rtl/io_wait_chk.sv
module io_wait_chk (
  input logic clk,
  input logic rst_n,
  input logic io_rd_n,
  input logic io_wr_n,
  input logic mem_rd_n,
  input logic chan_rdy,
  input logic zws_n,
  input logic cpu_ready,
  input logic dma_ready
);
  logic strobe;
  assign strobe = !io_rd_n || !io_wr_n || !mem_rd_n;

  // R9
  ready_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready == dma_ready);

  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> cpu_ready);

  // R2
  fall_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_ready) |-> $past(strobe));

  // R6
  zws_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zws_n && strobe) |=> cpu_ready);

  // R5
  rise_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ready) |-> ($past(!zws_n) || $past(!strobe) || $past(chan_rdy, 3)));
endmodule

bind io_wait_gen io_wait_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
  .mem_rd_n(mem_rd_n), .chan_rdy(chan_rdy), .zws_n(zws_n),
  .cpu_ready(cpu_ready), .dma_ready(dma_ready)
);

// File: tb/tb_io_wait_gen.sv
`timescale 1ns/1ps
module tb_io_wait_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_rd_n = 1'b1, io_wr_n = 1'b1, mem_rd_n = 1'b1;
  logic chan_rdy = 1'b1, zws_n = 1'b1;
  logic [2:0] io_waits = 3'd0;
  logic cpu_ready, dma_ready;
  int total = 0, bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  io_wait_gen dut (
    .clk(clk), .rst_n(rst_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .mem_rd_n(mem_rd_n), .chan_rdy(chan_rdy), .zws_n(zws_n),
    .io_waits(io_waits), .cpu_ready(cpu_ready), .dma_ready(dma_ready)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 I/O read, 1 I/O write, 2 memory read
  function automatic int exp_low(input int kind, input int cnt, input int k, input int z);
    int n, nat;
    n   = (kind == 2) ? 0 : ((cnt > 4) ? 4 : cnt);
    nat = n + 1;
    if (k > 0 && k + 2 > nat) nat = k + 2;
    if (z >= 0 && z < nat) return z;
    return nat;
  endfunction

  task automatic set_strobe(input int kind, input logic v);
    case (kind)
      0: io_rd_n = v;
      1: io_wr_n = v;
      default: mem_rd_n = v;
    endcase
  endtask

  // k: edge before which chan_rdy rises (0 = stays high); z: zws edge (-1 none)
  task automatic run_cycle(input int kind, input int cnt, input int k, input int z,
                           input string req);
    int low = 0;
    @(negedge clk);
    if (k > 0) begin
      chan_rdy = 1'b0;
      repeat (3) begin
        @(negedge clk);
        check("R10 idle chan_rdy low", int'(cpu_ready), 1);
      end
    end
    io_waits = 3'(cnt);
    set_strobe(kind, 1'b0);
    zws_n = (z == 0) ? 1'b0 : 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R9 dma_ready", int'(dma_ready), int'(cpu_ready));
      zws_n = (z == i + 1) ? 1'b0 : 1'b1;
      if (k > 0 && k == i + 1) chan_rdy = 1'b1;
      if (cpu_ready) break;
      low++;
    end
    zws_n = 1'b1;
    chan_rdy = 1'b1;
    check(req, low, exp_low(kind, cnt, k, z));
    repeat (2) begin
      @(negedge clk);
      check("R7 held strobe", int'(cpu_ready), 1);
    end
    set_strobe(kind, 1'b0);
    set_strobe(kind, 1'b1);
    @(negedge clk);
    check("R7 after release", int'(cpu_ready), 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1 in reset cpu", int'(cpu_ready), 1);
    check("R1 in reset dma", int'(dma_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", int'(cpu_ready), 1);

    // R10: zws_n low while idle
    zws_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 idle zws", int'(cpu_ready), 1);
    zws_n = 1'b1;

    // R2 / R3: all counts on I/O read and write
    for (int c = 0; c < 8; c++) begin
      run_cycle(0, c, 0, -1, (c > 4) ? "R3 clamp ior" : "R2 ior waits");
      run_cycle(1, c, 0, -1, (c > 4) ? "R3 clamp iow" : "R2 iow waits");
    end
    // R4: memory ignores count
    run_cycle(2, 0, 0, -1, "R4 memrd cnt0");
    run_cycle(2, 7, 0, -1, "R4 memrd cnt7");
    // R5: stretching
    run_cycle(0, 1, 1, -1, "R5 short stretch");
    run_cycle(0, 2, 6, -1, "R5 long stretch");
    run_cycle(2, 3, 4, -1, "R5 memrd stretch");
    // R6: zero wait
    run_cycle(0, 4, 0, 0, "R6 zws at start");
    run_cycle(1, 4, 0, 2, "R6 zws mid wait");
    run_cycle(0, 4, 8, 3, "R6 zws during stretch");
    run_cycle(0, 1, 0, 5, "R6 zws late no effect");

    // R8: abort
    @(negedge clk);
    io_waits = 3'd4;
    io_rd_n = 1'b0;
    @(negedge clk);
    check("R8 low before abort", int'(cpu_ready), 0);
    @(negedge clk);
    io_rd_n = 1'b1;
    @(negedge clk);
    check("R8 abort release", int'(cpu_ready), 1);
    @(negedge clk);

    // Random mix
    for (int t = 0; t < 60; t++) begin
      int kind, cnt, k, z;
      kind = int'($urandom_range(0, 2));
      cnt  = int'($urandom_range(0, 7));
      k    = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 8)) : 0;
      z    = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 8)) : -1;
      run_cycle(kind, cnt, k, z, "R5 R6 random cycle");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule